// File: doc/BRIEF.md
# Flash write status reporter

This block sits in the read return path of a flash controller. While an internal program or erase runs, it replaces the top two bits of each byte returned to the host with progress status. The top bit (D7) is a polarity flag. During a program it carries the inverse of the most significant bit being written. During an erase it reads low. The next bit (D6) is a flip flag that takes the opposite value on every read the host makes. Once the operation ends, the flip flag stops and the top bit goes back to the stored value.

The block also models the short unsettled window after completion. On the first read after the operation finishes, D7 and D6 already show the stored value, but D5..D0 come from a fixed fill pattern. Every read after that returns the full stored byte.

The controller supplies a busy level, the operation kind, the target top bit, a range flag for the current address and the stored byte. Each read strobe is answered one clock later with a registered byte and an acknowledge pulse.

Top module: `fsw_status_top`

## Requirements
- R1: While reset is asserted and right after it, `rd_byte` is 0 and `rd_ack` is 0.
- R2: `rd_ack` is high exactly in the cycle after a cycle with `rd_req` high, and `rd_byte` is updated only then. At all other times it holds its value.
- R3: A read with no operation active and no unsettled window pending returns `array_byte` unchanged.
- R4: A read during a program with `addr_ok`=1 returns bit 7 equal to the inverse of the target bit captured at operation start.
- R5: A read during an erase with `addr_ok`=1 returns bit 7 equal to 0.
- R6: During an operation, bit 6 of the returned byte is 0 on the first read after the start and inverts on each later read. Idle clock cycles without a read do not change it.
- R7: During an operation, bits 5..0 of the returned byte are the bits of `array_byte`.
- R8: The first read after completion returns bits 7 and 6 from `array_byte` and bits 5..0 from the fill pattern 6'b101010. Later reads return `array_byte` in full.
- R9: A read during an operation with `addr_ok`=0 returns bit 7 from `array_byte`, while bit 6 still carries the flip flag and advances it.
- R10: A read in the same clock in which `op_busy` falls still reports in-progress status. The unsettled read is the next one.
- R11: The operation kind and target bit are captured on the rising edge of `op_busy`. Changes to `op_is_erase` or `prog_msb` during the operation have no effect on reads.
- R12: A new operation that starts before the unsettled read is taken cancels that read. Reads after the new operation ends see the new unsettled window only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_busy | input | 1 | High while an internal program or erase runs |
| op_is_erase | input | 1 | Operation kind at start: 1 erase, 0 program |
| prog_msb | input | 1 | Top bit of the value being programmed |
| rd_req | input | 1 | Host read strobe, one cycle per read |
| addr_ok | input | 1 | Current read address lies in the valid range |
| array_byte | input | DATA_W | Stored value at the accessed location |
| rd_byte | output | DATA_W | Byte returned to the host |
| rd_ack | output | 1 | Pulse marking a new `rd_byte` |

## Verification
Two events can land in the same clock. A read strobe can coincide with the falling edge of `op_busy`, which is completion. A read strobe can also coincide with the rising edge, which is the start of a new operation. The bench produces both by raising `rd_req` in the very cycle that `op_busy` changes. A behavioural model, updated on every clock, defines the outcome. A read on completion must still show the polarity and flip flags, and the unsettled read must come next. A read on start must see the state before the operation, and the flip flag must then begin at 0.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic [1:0] {
    RD_PLAIN  = 2'd0,
    RD_STATUS = 2'd1,
    RD_SETTLE = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/fsw_op_track.sv
module fsw_op_track (
  input  logic clk,
  input  logic rst_n,
  input  logic op_busy,
  input  logic op_is_erase,
  input  logic prog_msb,
  input  logic settle_take,
  output logic active_q,
  output logic erase_q,
  output logic tgt_q,
  output logic settle_q,
  output logic op_start,
  output logic op_done
);
  assign op_start = op_busy && !active_q;
  assign op_done  = !op_busy && active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      erase_q  <= 1'b0;
      tgt_q    <= 1'b0;
      settle_q <= 1'b0;
    end else begin
      active_q <= op_busy;
      if (op_start) begin
        erase_q  <= op_is_erase;
        tgt_q    <= prog_msb;
        settle_q <= 1'b0;
      end else if (op_done) begin
        settle_q <= 1'b1;
      end else if (settle_take) begin
        settle_q <= 1'b0;
      end
    end
  end

  a_r8_settle_arm: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> settle_q);
  a_r12_start_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !settle_q);
  a_r11_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && op_busy) |=> ($stable(erase_q) && $stable(tgt_q)));
endmodule

// File: rtl/fsw_toggle.sv
module fsw_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic tog_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (clear)   tog_q <= 1'b0;
    else if (advance) tog_q <= !tog_q;
  end

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !tog_q);
  a_r6_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear) |=> (tog_q != $past(tog_q)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clear) |=> $stable(tog_q));
endmodule

// File: rtl/fsw_out_mux.sv
module fsw_out_mux
  import fsw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-3:0] FILL = 6'b101010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  rd_kind_e          rd_kind,
  input  logic              erase_q,
  input  logic              tgt_q,
  input  logic              tog_q,
  input  logic              addr_ok,
  input  logic [DATA_W-1:0] array_byte,
  output logic [DATA_W-1:0] rd_byte,
  output logic              rd_ack
);
  localparam int MSB = DATA_W - 1;
  localparam int TGL = DATA_W - 2;

  function automatic logic [DATA_W-1:0] build_byte(
    input rd_kind_e          kind,
    input logic              ers,
    input logic              tgt,
    input logic              tog,
    input logic              in_range,
    input logic [DATA_W-1:0] stored
  );
    logic [DATA_W-1:0] b;
    b = stored;
    case (kind)
      RD_STATUS: begin
        b[TGL] = tog;
        if (in_range) b[MSB] = ers ? 1'b0 : !tgt;
      end
      RD_SETTLE: b[TGL-1:0] = FILL;
      default:   b = stored;
    endcase
    return b;
  endfunction

  logic [DATA_W-1:0] next_byte;
  assign next_byte = build_byte(rd_kind, erase_q, tgt_q, tog_q, addr_ok, array_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_byte <= '0;
      rd_ack  <= 1'b0;
    end else begin
      rd_ack <= rd_req;
      if (rd_req) rd_byte <= next_byte;
    end
  end

  a_r2_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_ack);
  a_r2_noack: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rd_ack && $stable(rd_byte)));
endmodule

// File: rtl/fsw_status_top.sv
module fsw_status_top
  import fsw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-3:0] SETTLE_FILL = 6'b101010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_busy,
  input  logic              op_is_erase,
  input  logic              prog_msb,
  input  logic              rd_req,
  input  logic              addr_ok,
  input  logic [DATA_W-1:0] array_byte,
  output logic [DATA_W-1:0] rd_byte,
  output logic              rd_ack
);
  localparam int MSB = DATA_W - 1;
  localparam int TGL = DATA_W - 2;

  logic active_q, erase_q, tgt_q, settle_q, op_start, op_done, tog_q;
  logic status_rd, settle_rd;
  rd_kind_e rd_kind;

  assign status_rd = rd_req && active_q;
  assign settle_rd = rd_req && !active_q && settle_q;
  assign rd_kind   = active_q ? RD_STATUS : (settle_q ? RD_SETTLE : RD_PLAIN);

  fsw_op_track u_track (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_is_erase(op_is_erase),
    .prog_msb(prog_msb), .settle_take(settle_rd), .active_q(active_q),
    .erase_q(erase_q), .tgt_q(tgt_q), .settle_q(settle_q),
    .op_start(op_start), .op_done(op_done)
  );

  fsw_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .clear(op_start), .advance(status_rd), .tog_q(tog_q)
  );

  fsw_out_mux #(.DATA_W(DATA_W), .FILL(SETTLE_FILL)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_kind(rd_kind),
    .erase_q(erase_q), .tgt_q(tgt_q), .tog_q(tog_q), .addr_ok(addr_ok),
    .array_byte(array_byte), .rd_byte(rd_byte), .rd_ack(rd_ack)
  );

  a_r4_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !erase_q && addr_ok) |=> (rd_byte[MSB] == !$past(tgt_q)));
  a_r5_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && erase_q && addr_ok) |=> !rd_byte[MSB]);
  a_r6_flag_out: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (rd_byte[TGL] == $past(tog_q)));
  a_r10_done_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && op_done) |=> settle_q);
  a_r8_settle_fill: assert property (@(posedge clk) disable iff (!rst_n)
    settle_rd |=> (rd_byte[TGL-1:0] == SETTLE_FILL));
endmodule

// File: tb/fsw_status_top_bench.sv
module fsw_status_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_busy = 1'b0, op_is_erase = 1'b0, prog_msb = 1'b0;
  logic rd_req = 1'b0, addr_ok = 1'b1;
  logic [7:0] array_byte = 8'h00;
  logic [7:0] rd_byte;
  logic rd_ack;

  always #5 clk = !clk;

  fsw_status_top u_fsw_status_top (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_is_erase(op_is_erase),
    .prog_msb(prog_msb), .rd_req(rd_req), .addr_ok(addr_ok),
    .array_byte(array_byte), .rd_byte(rd_byte), .rd_ack(rd_ack)
  );

  int n_run = 0, n_fail = 0;
  bit running = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: state of the host-visible protocol
  bit m_prev_busy = 0, m_kind = 0, m_tgt = 0, m_flag = 0, m_unsettled = 0;
  bit m_new_op_cancel = 0;
  logic [7:0] e_byte = 8'h00;
  bit e_ack = 0;
  string e_tag = "R1";
  localparam logic [5:0] FILL_PAT = 6'b101010;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev_busy = 0; m_kind = 0; m_tgt = 0; m_flag = 0; m_unsettled = 0;
      m_new_op_cancel = 0; e_byte = 8'h00; e_ack = 0; e_tag = "R1";
    end else begin
      e_ack = rd_req;
      if (rd_req) begin
        if (m_prev_busy) begin
          e_byte = array_byte;
          e_byte[6] = m_flag;
          if (addr_ok) begin
            e_byte[7] = m_kind ? 1'b0 : !m_tgt;
            e_tag = m_kind ? "R5 R6 R7 R11" : "R4 R6 R7 R11";
          end else e_tag = "R9";
          if (!op_busy) e_tag = "R10";
          m_flag = !m_flag;
        end else if (m_unsettled) begin
          e_byte = {array_byte[7:6], FILL_PAT};
          e_tag = "R8";
          m_unsettled = 0;
        end else begin
          e_byte = array_byte;
          e_tag = m_new_op_cancel ? "R12" : "R3";
        end
      end
      if (op_busy && !m_prev_busy) begin
        if (m_unsettled) m_new_op_cancel = 1;
        m_flag = 0; m_kind = op_is_erase; m_tgt = prog_msb; m_unsettled = 0;
      end else if (!op_busy && m_prev_busy) begin
        m_unsettled = 1;
      end
      m_prev_busy = op_busy;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R2", {7'b0, rd_ack}, {7'b0, e_ack});
      chk(e_tag, rd_byte, e_byte);
    end
  end

  task automatic cyc(input logic b, input logic e, input logic t, input logic r,
                     input logic a, input logic [7:0] d);
    @(negedge clk);
    op_busy = b; op_is_erase = e; prog_msb = t; rd_req = r; addr_ok = a; array_byte = d;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", rd_byte, 8'h00);
    chk("R1", {7'b0, rd_ack}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {7'b0, rd_ack}, 8'h00);
    running = 1'b1;
    // R3 plain reads, back to back and spaced
    cyc(0,0,0,1,1,8'h5A); cyc(0,0,0,1,1,8'hC3); cyc(0,0,0,0,1,8'h11);
    cyc(0,0,0,1,0,8'h7E); cyc(0,0,0,0,1,8'h00);
    // R4 program, target msb 1; read on the start cycle sees pre-op state
    cyc(1,0,1,1,1,8'h3C);
    cyc(1,0,1,1,1,8'h3C); cyc(1,0,1,1,1,8'h81);
    cyc(1,0,1,0,1,8'h81); cyc(1,0,1,0,1,8'h81);   // R6 no advance without reads
    cyc(1,1,0,1,1,8'hA5);                         // R11 inputs change mid-op
    cyc(1,1,0,1,0,8'hF0);                         // R9 out of range
    cyc(1,1,0,1,1,8'h0F);
    // completion without a read, then unsettled read, then full data (R8)
    cyc(0,0,0,0,1,8'h9B); cyc(0,0,0,0,1,8'h9B);
    cyc(0,0,0,1,1,8'h9B); cyc(0,0,0,1,1,8'h9B); cyc(0,0,0,1,1,8'h64);
    // R5 erase, ending with a read in the completion clock (R10)
    cyc(1,1,0,0,1,8'h00);
    cyc(1,1,0,1,1,8'h12); cyc(1,1,0,1,1,8'h34); cyc(1,1,0,1,1,8'h7F);
    cyc(0,1,0,1,1,8'hFF);
    cyc(0,0,0,1,1,8'hFF); cyc(0,0,0,1,1,8'hFF);
    // R12 program ends, new program starts before any read
    cyc(1,0,0,0,1,8'h00); cyc(1,0,0,1,1,8'h40); cyc(0,0,0,0,1,8'h40);
    cyc(1,0,0,0,1,8'h40); cyc(1,0,0,1,1,8'h40); cyc(1,0,0,1,1,8'h40);
    cyc(0,0,0,0,1,8'hC8); cyc(0,0,0,1,1,8'hC8); cyc(0,0,0,1,1,8'hC8);
    // read in the start clock of an erase after idle
    cyc(1,1,1,1,1,8'h55); cyc(1,1,1,1,1,8'h55); cyc(0,0,0,1,1,8'h55);
    cyc(0,0,0,1,1,8'hAA); cyc(0,0,0,0,1,8'hAA);
    cyc(0,0,0,0,1,8'hAA); cyc(0,0,0,0,1,8'hAA);
    running = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule